// File: doc/BRIEF.md
# Banked ROM Window Controller

This block sits on the bus of an 8-bit CPU and controls the 16 KiB window at the top of its address space ($C000 to $FFFF). A bank register selects which bank the window shows. Banks below a configurable onboard count (32 by default) are served by onboard ROM. Higher banks are routed to memory on an expansion card, which can also be written, so code under development can be loaded into it. Each bus cycle, the block decodes the address, the read/write line and the effective bank into active-low chip, output and write enables.

The bank register sits at one I/O address ($0001 by default). A write there takes effect at the next clock edge. A read there returns the stored value. When the CPU signals an interrupt vector fetch, the effective bank is forced to 0 so the vectors always come from valid ROM. The override then stays in force until software next writes the bank register. The stored selection is kept unchanged underneath the override, so software can read it back and restore it.

The card receives the low bits of the bank number as extra address lines. A registered, stretched activity output reports card accesses; it is not taken from any enable line.

Top module: `rom_window_ctrl`

## Requirements
- R1: Chip enables are asserted only when address bits 15 and 14 are both 1. Outside $C000–$FFFF, `rom_ce_n`, `card_ce_n`, `rom_oe_n`, `card_oe_n` and `card_we_n` are all 1.
- R2: In the window with an effective bank below 32, `rom_ce_n` is 0, `rom_oe_n` is 0 on reads (`cpu_rw`=1), and all card enables are 1.
- R3: In the window with an effective bank of 32 or more, `card_ce_n` is 0 and the ROM enables are 1. Reads drive `card_oe_n` to 0 and writes (`cpu_rw`=0) drive `card_we_n` to 0. Whenever the effective bank is 32 or more, `card_bank` carries its low 5 bits; otherwise `card_bank` is 0.
- R4: After reset, the stored bank is 0, no override is active and `card_act` is 0.
- R5: While `cpu_vp_n` is 0, `bank_sel` is 0. The override then takes effect at the clock edge.
- R6: The override keeps `bank_sel` at 0 until a write to $0001. That write stores `cpu_din` and clears the override at the same edge. If a vector fetch and a bank write occur in the same cycle, the write takes precedence.
- R7: A read at $0001 drives `reg_oe` to 1 and `reg_dout` to the stored bank, even while the override is active. Otherwise `reg_oe` is 0 and `reg_dout` is 0.
- R8: A write into the window with an onboard bank asserts no output or write enable.
- R9: `card_act` is 1 from the cycle after any card access until 4 cycles after the last one. Onboard accesses never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_din | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_vp_n | input | 1 | Active-low vector fetch indicator |
| bank_sel | output | 8 | Effective bank number |
| reg_dout | output | 8 | Stored bank value on register reads |
| reg_oe | output | 1 | Register read data valid |
| rom_ce_n | output | 1 | Onboard ROM chip enable |
| rom_oe_n | output | 1 | Onboard ROM output enable |
| card_ce_n | output | 1 | Card memory chip enable |
| card_oe_n | output | 1 | Card memory output enable |
| card_we_n | output | 1 | Card memory write enable |
| card_bank | output | 5 | Card high address lines from the bank |
| card_act | output | 1 | Stretched card activity indicator |

## Verification
Two functions can act in the same cycle: setting the vector override and writing the bank register. The bench drives `cpu_vp_n` low during a write to $0001, both as a directed case and from random stimulus. It then checks at the following cycle that the written bank appears on `bank_sel` with no override. A card access in the cycle the activity stretch runs out is a second collision. The bench judges it by the reference counter reloading instead of expiring.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_ROM  = 2'd1,
    ACC_CARD = 2'd2
  } acc_e;
endpackage

// File: rtl/rwc_bank_reg.sv
module rwc_bank_reg #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] din,
  input  logic              rw,
  input  logic              vp_n,
  output logic [BANK_W-1:0] eff_bank,
  output logic [BANK_W-1:0] stored_bank,
  output logic              reg_rd
);
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              ovr_q, ovr_d;
  logic              hit, wr_en, vec;

  assign hit   = (addr == REG_ADDR);
  assign wr_en = hit & ~rw;
  assign vec   = ~vp_n;

  // Next state: a register write wins over a vector fetch in the same cycle
  always_comb begin
    bank_d = bank_q;
    ovr_d  = ovr_q;
    if (wr_en) begin
      bank_d = din;
      ovr_d  = 1'b0;
    end else if (vec) begin
      ovr_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      bank_q <= bank_d;
      ovr_q  <= ovr_d;
    end
  end

  assign eff_bank    = (vec | ovr_q) ? '0 : bank_q;
  assign stored_bank = bank_q;
  assign reg_rd      = hit & rw;
endmodule

// File: rtl/rwc_decode.sv
module rwc_decode
  import rwc_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int BANK_W        = 8,
  parameter int ONBOARD_BANKS = 32,
  localparam int CARD_AW      = $clog2(ONBOARD_BANKS)
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rw,
  input  logic [BANK_W-1:0]  eff_bank,
  output acc_e               acc,
  output logic               rom_ce_n,
  output logic               rom_oe_n,
  output logic               card_ce_n,
  output logic               card_oe_n,
  output logic               card_we_n,
  output logic [CARD_AW-1:0] card_bank
);
  logic in_window, card_sel;

  assign in_window = addr[ADDR_W-1] & addr[ADDR_W-2];
  assign card_sel  = (eff_bank >= BANK_W'(ONBOARD_BANKS));

  always_comb begin
    acc = ACC_IDLE;
    if (in_window) acc = card_sel ? ACC_CARD : ACC_ROM;
  end

  always_comb begin
    rom_ce_n  = 1'b1;
    rom_oe_n  = 1'b1;
    card_ce_n = 1'b1;
    card_oe_n = 1'b1;
    card_we_n = 1'b1;
    unique case (acc)
      ACC_ROM: begin
        rom_ce_n = 1'b0;
        rom_oe_n = ~rw;
      end
      ACC_CARD: begin
        card_ce_n = 1'b0;
        card_oe_n = ~rw;
        card_we_n = rw;
      end
      default: ;
    endcase
  end

  assign card_bank = card_sel ? eff_bank[CARD_AW-1:0] : '0;
endmodule

// File: rtl/rwc_activity.sv
module rwc_activity #(
  parameter int PULSE_LEN = 4,
  localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic act
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hit)              cnt_d = CNT_W'(PULSE_LEN);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    act_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/rom_window_ctrl.sv
module rom_window_ctrl
  import rwc_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int BANK_W        = 8,
  parameter int ONBOARD_BANKS = 32,
  parameter int PULSE_LEN     = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0001,
  localparam int CARD_AW      = $clog2(ONBOARD_BANKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [BANK_W-1:0]  cpu_din,
  input  logic               cpu_rw,
  input  logic               cpu_vp_n,
  output logic [BANK_W-1:0]  bank_sel,
  output logic [BANK_W-1:0]  reg_dout,
  output logic               reg_oe,
  output logic               rom_ce_n,
  output logic               rom_oe_n,
  output logic               card_ce_n,
  output logic               card_oe_n,
  output logic               card_we_n,
  output logic [CARD_AW-1:0] card_bank,
  output logic               card_act
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [BANK_W-1:0] eff_bank, stored_bank;
  logic              reg_rd;
  acc_e              acc;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  rwc_bank_reg #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_ADDR(REG_ADDR)
  ) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .addr(cpu_addr), .din(cpu_din),
    .rw(cpu_rw), .vp_n(cpu_vp_n), .eff_bank(eff_bank),
    .stored_bank(stored_bank), .reg_rd(reg_rd)
  );

  rwc_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ONBOARD_BANKS(ONBOARD_BANKS)
  ) u_dec (
    .addr(cpu_addr), .rw(cpu_rw), .eff_bank(eff_bank), .acc(acc),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .card_ce_n(card_ce_n),
    .card_oe_n(card_oe_n), .card_we_n(card_we_n), .card_bank(card_bank)
  );

  rwc_activity #(.PULSE_LEN(PULSE_LEN)) u_act (
    .clk(clk), .rst_n(rst_sync_n), .hit(acc == ACC_CARD), .act(card_act)
  );

  assign bank_sel = eff_bank;
  assign reg_oe   = reg_rd;
  assign reg_dout = reg_rd ? stored_bank : '0;
endmodule

// File: rtl/rwc_checker.sv
module rwc_checker #(
  parameter int ADDR_W        = 16,
  parameter int BANK_W        = 8,
  parameter int ONBOARD_BANKS = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0001
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [BANK_W-1:0] cpu_din,
  input logic              cpu_rw,
  input logic              cpu_vp_n,
  input logic [BANK_W-1:0] bank_sel,
  input logic [BANK_W-1:0] reg_dout,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic              card_ce_n,
  input logic              card_we_n,
  input logic              card_act
);
  logic win, reg_wr, reg_rd;
  assign win    = cpu_addr[ADDR_W-1] & cpu_addr[ADDR_W-2];
  assign reg_wr = (cpu_addr == REG_ADDR) & ~cpu_rw;
  assign reg_rd = (cpu_addr == REG_ADDR) & cpu_rw;

  p_window_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> (rom_ce_n && card_ce_n));

  p_card_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !cpu_rw && bank_sel >= BANK_W'(ONBOARD_BANKS)) |-> !card_we_n);

  p_vector_bank0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_vp_n |-> (bank_sel == '0));

  p_override_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_vp_n && !reg_wr) |=> (bank_sel == '0));

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (!cpu_vp_n || bank_sel == $past(cpu_din)));

  p_shadow_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (!reg_rd || reg_dout == $past(cpu_din)));

  p_onboard_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && !cpu_rw) |-> (rom_oe_n && card_we_n));

  p_activity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !card_ce_n |=> card_act);
endmodule

bind rom_window_ctrl rwc_checker #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ONBOARD_BANKS(ONBOARD_BANKS),
  .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
  .cpu_rw(cpu_rw), .cpu_vp_n(cpu_vp_n), .bank_sel(bank_sel),
  .reg_dout(reg_dout), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
  .card_ce_n(card_ce_n), .card_we_n(card_we_n), .card_act(card_act)
);

// File: tb/tb_rom_window_ctrl.sv
module tb_rom_window_ctrl;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_din;
  logic        cpu_rw;
  logic        cpu_vp_n;
  logic [7:0]  bank_sel, reg_dout;
  logic        reg_oe, rom_ce_n, rom_oe_n, card_ce_n, card_oe_n, card_we_n;
  logic [4:0]  card_bank;
  logic        card_act;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state
  logic [7:0] m_bank;
  logic       m_ovr;
  int         m_cnt;

  always #2 clk = ~clk;

  rom_window_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
    .cpu_rw(cpu_rw), .cpu_vp_n(cpu_vp_n), .bank_sel(bank_sel),
    .reg_dout(reg_dout), .reg_oe(reg_oe), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .card_ce_n(card_ce_n), .card_oe_n(card_oe_n),
    .card_we_n(card_we_n), .card_bank(card_bank), .card_act(card_act)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (addr %04h rw %0b vp_n %0b)",
               tag, got, exp, cpu_addr, cpu_rw, cpu_vp_n);
    end
  endtask

  function automatic logic [7:0] exp_bank(input logic vp_n);
    return (!vp_n || m_ovr) ? 8'd0 : m_bank;
  endfunction

  function automatic int exp_enables(input logic [15:0] a, input logic rw,
                                     input logic [7:0] eb);
    logic win, card;
    win  = a[15] & a[14];
    card = eb >= 8'd32;
    // packed {rom_ce_n, rom_oe_n, card_ce_n, card_oe_n, card_we_n}
    return {27'd0,
            !(win && !card), !(win && !card && rw),
            !(win && card), !(win && card && rw), !(win && card && !rw)};
  endfunction

  // One bus cycle: drive at falling edge, compare, then advance the model
  task automatic bus(input logic [15:0] a, input logic rw, input logic vp_n,
                     input logic [7:0] d);
    logic [7:0] eb;
    int en;
    bit win, card, rd_reg;
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; cpu_vp_n = vp_n; cpu_din = d;
    #1;
    eb  = exp_bank(vp_n);
    en  = exp_enables(a, rw, eb);
    win = a[15] & a[14];
    card = eb >= 8'd32;
    rd_reg = (a == 16'h0001) && rw;
    chk(win ? (card ? "R3 card enables" : (rw ? "R2 rom enables" : "R8 onboard write"))
            : "R1 outside window",
        {27'd0, rom_ce_n, rom_oe_n, card_ce_n, card_oe_n, card_we_n}, en);
    chk(vp_n ? "R6 bank_sel" : "R5 bank_sel on vector", bank_sel, eb);
    chk("R3 card_bank", card_bank, card ? int'(eb[4:0]) : 0);
    chk("R7 register read", {reg_oe, reg_dout}, rd_reg ? {1'b1, m_bank} : 9'd0);
    chk("R9 card_act", card_act, m_cnt != 0);
    @(posedge clk);
    if (a == 16'h0001 && !rw) begin m_bank = d; m_ovr = 1'b0; end
    else if (!vp_n) m_ovr = 1'b1;
    if (win && card) m_cnt = PULSE;
    else if (m_cnt > 0) m_cnt--;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b0; cpu_addr = '0; cpu_rw = 1'b1; cpu_vp_n = 1'b1; cpu_din = '0;
    m_bank = '0; m_ovr = 1'b0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R4: reset state seen at the ports
    bus(16'h0001, 1'b1, 1'b1, 8'h00);
    bus(16'hC000, 1'b1, 1'b1, 8'h00);

    // R2/R3 boundary at banks 31 and 32, R8 onboard write
    bus(16'h0001, 1'b0, 1'b1, 8'd31);
    bus(16'hC123, 1'b1, 1'b1, 8'h00);
    bus(16'hFFFF, 1'b0, 1'b1, 8'hAA);
    bus(16'h0001, 1'b0, 1'b1, 8'd32);
    bus(16'hC000, 1'b1, 1'b1, 8'h00);
    bus(16'hE000, 1'b0, 1'b1, 8'h55);
    // R1 just below the window with a card bank
    bus(16'hBFFF, 1'b0, 1'b1, 8'h00);
    // R9: stretch expires, then a re-trigger on the last stretched cycle
    repeat (PULSE + 1) bus(16'h2000, 1'b1, 1'b1, 8'h00);
    bus(16'hC000, 1'b1, 1'b1, 8'h00);
    repeat (PULSE - 1) bus(16'h2000, 1'b1, 1'b1, 8'h00);
    bus(16'hD000, 1'b1, 1'b1, 8'h00);
    repeat (PULSE + 1) bus(16'h2000, 1'b1, 1'b1, 8'h00);

    // R5/R6/R7: vector fetch with card bank 0xFF, override holds, shadow readable
    bus(16'h0001, 1'b0, 1'b1, 8'hFF);
    bus(16'hFFFA, 1'b1, 1'b0, 8'h00);
    bus(16'hFFFB, 1'b1, 1'b0, 8'h00);
    bus(16'hC400, 1'b1, 1'b1, 8'h00);
    bus(16'h0001, 1'b1, 1'b1, 8'h00);
    // R6: vector fetch and bank write in the same cycle, write wins
    bus(16'h0001, 1'b0, 1'b0, 8'h40);
    bus(16'hC000, 1'b0, 1'b1, 8'h11);
    bus(16'h0001, 1'b1, 1'b1, 8'h00);

    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 5)       a = {2'b11, 14'($urandom)};
      else if (sel < 7)  a = 16'h0001;
      else               a = 16'($urandom);
      bus(a, 1'($urandom), ($urandom_range(0, 11) != 0), 8'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule